// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This unit sits beside an instruction cache and holds a short FIFO of blocks fetched ahead of demand. When the cache reports a miss, the unit compares the miss block address with the oldest buffered block only. On a match, that block is returned straight from the buffer, the entry is retired, and the freed slot is refilled with the next block in sequence. On a mismatch, the buffer is emptied and the unit fetches the missed block from memory for the cache. It then restarts the sequential stream at the block after the miss and fills the buffer while the memory port is otherwise idle.

The miss request, the miss response and the memory request are valid/ready streams. A transfer happens on any rising clock edge where valid and ready are both high. Once valid is raised, it and the payload stay stable until that edge. `miss_ready` is high only while no miss is being served, so the cache is back-pressured for the whole life of a miss. `resp_ready` low holds the response in place. The memory response has no ready. The unit always accepts it, because it keeps at most one request outstanding. `flush` is a plain control pin. It empties the buffer and halts prefetching until the next miss.

Top module: `sbuf_prefetcher`

## Requirements
- R1: A miss that does not match the buffer head is answered with `resp_hit`=0 and the memory data for the miss address with its low log2(BLK_BYTES) bits cleared. Those low bits are ignored everywhere.
- R2: After a demand miss on block X, the unit requests X+B, X+2B, … (B = BLK_BYTES). It stops once DEPTH (4) blocks are buffered and issues no further request while the buffer stays full.
- R3: A miss equal to a valid head address is answered with `resp_hit`=1 and the buffered data, with no memory request for that block. The head is retired and exactly one further sequential block is requested.
- R4: Only the head is compared. A miss equal to a deeper entry is treated as a mismatch: the buffer is cleared and the stream restarts at the miss block plus B.
- R5: After a mismatching miss, no new prefetch is issued ahead of the demand. The next request sent after any already presented request is the demand block.
- R6: At most one memory request is outstanding. `mem_req_valid` is not raised again until the response to the previous request has arrived.
- R7: `flush` empties the buffer and stops prefetching until the next miss. A later miss on a formerly buffered block is a mismatch.
- R8: Prefetch data returning after the buffer was cleared, by `flush` or by a mismatching miss, is discarded and never becomes a buffer entry.
- R9: Prefetch addresses advance by B modulo 2^AW, so a stream wraps from the top of the address space to zero.
- R10: Valid/ready rules hold. `miss_ready` is high only when idle. A stalled response keeps `resp_valid`, `resp_data` and `resp_hit` stable. A stalled memory request keeps its address. After reset, `miss_ready`=1 and both `resp_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the buffer and halt the stream |
| miss_valid | input | 1 | Cache miss request valid |
| miss_ready | output | 1 | Unit can take a miss |
| miss_addr | input | AW | Miss byte address |
| resp_valid | output | 1 | Block returned to cache is valid |
| resp_ready | input | 1 | Cache accepts the block |
| resp_data | output | DW | Returned block data |
| resp_hit | output | 1 | 1 when served from the buffer |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Block-aligned request address |
| mem_rsp_valid | input | 1 | Memory read data valid for one cycle |
| mem_rsp_data | input | DW | Memory read data |

## Verification
The case hardest to reach from the ports is a prefetch that is still in flight when the buffer is cleared. Memory must be slow enough that `flush` lands between the request handshake and the data return. The stimulus raises memory latency to 30 cycles and misses on a fresh block. It pulses `flush` right after the demand answer, while the first prefetch of the new stream is still outstanding. A follow-up miss on that very block must then come back as a mismatch. A wrongly kept stale block would turn it into a hit. Demand ordering is also observed. A hit immediately followed by a mismatching miss must log the hit's refill request, then the demand, then the new stream.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DREQ  = 2'd1,
    ST_DWAIT = 2'd2,
    ST_RESP  = 2'd3
  } sbuf_state_e;
endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [AW-1:0]                push_addr,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic                         head_valid,
  output logic [AW-1:0]                head_addr,
  output logic [DW-1:0]                head_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt_q;
  logic [DEPTH-1:0] ent_vld;
  logic [DEPTH-1:0] ent_we;
  logic [DEPTH-1:0] ent_re;
  logic [AW-1:0]    ent_addr [DEPTH];
  logic [DW-1:0]    ent_data [DEPTH];

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign ent_we[i] = push && (wr_ptr == PW'(i));
    assign ent_re[i] = pop  && (rd_ptr == PW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt_q   <= '0;
    end else if (clr) begin
      ent_vld <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt_q   <= '0;
    end else begin
      ent_vld <= (ent_vld & ~ent_re) | ent_we;
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (ent_we[k]) begin
        ent_addr[k] <= push_addr;
        ent_data[k] <= push_data;
      end
    end
  end

  assign head_valid = ent_vld[rd_ptr];
  assign head_addr  = ent_addr[rd_ptr];
  assign head_data  = ent_data[rd_ptr];
  assign count      = cnt_q;

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |-> (cnt_q < CW'(DEPTH))); // R2
  AST_FIFO_POP_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid); // R3
endmodule

// File: rtl/sbuf_memport.sv
module sbuf_memport #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_dem,
  input  logic          issue_pf,
  input  logic [AW-1:0] issue_addr,
  input  logic          kill,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          dem_done,
  output logic          pf_done
);
  logic          pend_q, wait_q, is_pf_q, drop_q;
  logic [AW-1:0] addr_q;
  logic          start;

  assign busy  = pend_q | wait_q;
  assign start = (issue_dem | issue_pf) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      wait_q  <= 1'b0;
      is_pf_q <= 1'b0;
      drop_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (start) begin
        pend_q  <= 1'b1;
        addr_q  <= issue_addr;
        is_pf_q <= !issue_dem;
        drop_q  <= 1'b0;
      end else if (pend_q && mem_req_ready) begin
        pend_q <= 1'b0;
        wait_q <= 1'b1;
      end else if (wait_q && mem_rsp_valid) begin
        wait_q <= 1'b0;
      end
      if (kill && busy && is_pf_q) drop_q <= 1'b1;
    end
  end

  assign mem_req_valid = pend_q;
  assign mem_req_addr  = addr_q;
  assign dem_done      = wait_q && mem_rsp_valid && !is_pf_q;
  assign pf_done       = wait_q && mem_rsp_valid && is_pf_q && !drop_q && !kill;

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
  AST_STALE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !pf_done); // R8
endmodule

// File: rtl/sbuf_prefetcher.sv
module sbuf_prefetcher #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int BLK_BYTES = 16,
  parameter int DEPTH     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          miss_valid,
  output logic          miss_ready,
  input  logic [AW-1:0] miss_addr,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [DW-1:0] resp_data,
  output logic          resp_hit,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  import sbuf_pkg::*;

  localparam int            CW   = $clog2(DEPTH+1);
  localparam logic [AW-1:0] STEP = AW'(BLK_BYTES);
  localparam logic [AW-1:0] LOWM = STEP - 1'b1;

  sbuf_state_e   st_q;
  logic          pf_on_q;
  logic [AW-1:0] pf_ptr_q, dem_addr_q;
  logic [DW-1:0] rdata_q;
  logic          rhit_q;

  logic          head_valid;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic [CW-1:0] fq_count;
  logic [AW-1:0] miss_blk;
  logic          miss_fire, head_match, buf_hit, buf_miss, clr_all;
  logic          busy, issue_dem, issue_pf, dem_done, pf_done;

  assign miss_ready = (st_q == ST_IDLE);
  assign miss_fire  = miss_valid && miss_ready;
  assign miss_blk   = miss_addr & ~LOWM;
  assign head_match = head_valid && (head_addr == miss_blk);
  assign buf_hit    = miss_fire && head_match;
  assign buf_miss   = miss_fire && !head_match;
  assign clr_all    = buf_miss || flush;

  assign issue_dem = (st_q == ST_DREQ);
  assign issue_pf  = pf_on_q && !flush && !busy
                   && (fq_count < CW'(DEPTH))
                   && (st_q != ST_DREQ)
                   && !((st_q == ST_IDLE) && miss_valid);

  sbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_all),
    .push       (pf_done),
    .push_addr  (mem_req_addr),
    .push_data  (mem_rsp_data),
    .pop        (buf_hit),
    .head_valid (head_valid),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .count      (fq_count)
  );

  sbuf_memport #(.AW(AW)) u_mem (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_dem     (issue_dem),
    .issue_pf      (issue_pf),
    .issue_addr    (issue_dem ? dem_addr_q : pf_ptr_q),
    .kill          (clr_all),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .dem_done      (dem_done),
    .pf_done       (pf_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pf_on_q    <= 1'b0;
      pf_ptr_q   <= '0;
      dem_addr_q <= '0;
      rdata_q    <= '0;
      rhit_q     <= 1'b0;
    end else begin
      if (flush) pf_on_q <= 1'b0;
      if (issue_pf) pf_ptr_q <= pf_ptr_q + STEP;
      case (st_q)
        ST_IDLE: begin
          if (buf_hit) begin
            rdata_q <= head_data;
            rhit_q  <= 1'b1;
            st_q    <= ST_RESP;
          end else if (buf_miss) begin
            dem_addr_q <= miss_blk;
            pf_ptr_q   <= miss_blk + STEP;
            pf_on_q    <= 1'b1;
            st_q       <= ST_DREQ;
          end
        end
        ST_DREQ:  if (!busy) st_q <= ST_DWAIT;
        ST_DWAIT: begin
          if (dem_done) begin
            rdata_q <= mem_rsp_data;
            rhit_q  <= 1'b0;
            st_q    <= ST_RESP;
          end
        end
        default:  if (resp_ready) st_q <= ST_IDLE;
      endcase
    end
  end

  assign resp_valid = (st_q == ST_RESP);
  assign resp_data  = rdata_q;
  assign resp_hit   = rhit_q;

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data) && $stable(resp_hit))); // R10
  AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DWAIT) && mem_req_valid) |-> (mem_req_addr == dem_addr_q)); // R5
  AST_HIT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    buf_hit |=> (resp_valid && resp_hit)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !head_valid); // R7
endmodule

// File: tb/tb_sbuf_prefetcher.sv
`timescale 1ns/1ps
module tb_sbuf_prefetcher;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic miss_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic resp_ready = 1'b1;
  logic mem_req_ready = 1'b1;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic miss_ready, resp_valid, resp_hit, mem_req_valid;
  logic [DW-1:0] resp_data;
  logic [AW-1:0] mem_req_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int lat     = 3;
  int viol    = 0;

  logic [DW:0]   exp_q[$];
  string         tag_q[$];
  logic [AW-1:0] req_log[$];
  logic [AW-1:0] exp_log[$];

  always #2.5 clk = ~clk;

  sbuf_prefetcher dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data), .resp_hit(resp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  logic [DW:0] mon_e;
  string       mon_t;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && resp_valid && resp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected response", 64'(resp_data), 64'd0);
        end else begin
          mon_e = exp_q.pop_front();
          mon_t = tag_q.pop_front();
          check(resp_data == mon_e[DW-1:0], mon_t, "resp_data", 64'(resp_data), 64'(mon_e[DW-1:0]));
          check(resp_hit == mon_e[DW], mon_t, "resp_hit", 64'(resp_hit), 64'(mon_e[DW]));
        end
      end
    end
  end

  // memory model: one response per request, fixed latency
  bit            m_out = 1'b0;
  int            m_cnt = 0;
  logic [AW-1:0] m_addr = '0;
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (m_out) begin
        if (m_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mdata(m_addr);
          m_out = 1'b0;
        end else begin
          m_cnt--;
        end
      end
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (m_out) viol++;
        req_log.push_back(mem_req_addr);
        m_out  = 1'b1;
        m_cnt  = lat;
        m_addr = mem_req_addr;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic do_miss(input logic [AW-1:0] a, input bit hit, input string tag, input bit wait_done);
    @(posedge clk); #1;
    exp_q.push_back({hit, mdata(a & 16'hFFF0)});
    tag_q.push_back(tag);
    miss_valid = 1'b1;
    miss_addr  = a;
    do @(negedge clk); while (!miss_ready);
    @(posedge clk); #1;
    miss_valid = 1'b0;
    if (wait_done) while (exp_q.size() != 0) @(posedge clk);
  endtask

  task automatic pulse_flush();
    @(posedge clk); #1;
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  task automatic check_log(input string req);
    check(req_log.size() == exp_log.size(), req, "request count",
          64'(req_log.size()), 64'(exp_log.size()));
    for (int i = 0; i < exp_log.size() && i < req_log.size(); i++)
      check(req_log[i] == exp_log[i], req, $sformatf("request %0d", i),
            64'(req_log[i]), 64'(exp_log[i]));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  localparam logic [AW-1:0] A = 16'h1230;
  localparam logic [AW-1:0] C = 16'h4000;
  localparam logic [AW-1:0] D = 16'h5000;
  logic [DW-1:0] held;

  initial begin
    idle(5);
    @(negedge clk);
    check(miss_ready == 1'b1, "R10", "reset miss_ready", 64'(miss_ready), 64'd1);
    check(resp_valid == 1'b0, "R10", "reset resp_valid", 64'(resp_valid), 64'd0);
    check(mem_req_valid == 1'b0, "R10", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    idle(3);

    // R1/R2: cold miss with unaligned address, stream fills the buffer
    do_miss(A + 16'd5, 1'b0, "R1", 1'b1);
    idle(100);
    exp_log = {A, A + 16'd16, A + 16'd32, A + 16'd48, A + 16'd64};
    check_log("R2");

    // R3: head hit, one refill request
    req_log.delete();
    do_miss(A + 16'd16, 1'b1, "R3", 1'b1);
    idle(60);
    exp_log = {A + 16'd80};
    check_log("R3");

    // R4: match on a deeper entry is a mismatch
    req_log.delete();
    do_miss(A + 16'd48, 1'b0, "R4", 1'b1);
    idle(80);
    exp_log = {A + 16'd48, A + 16'd64, A + 16'd80, A + 16'd96, A + 16'd112};
    check_log("R4");

    // R5: hit then immediate mismatch; demand ahead of new prefetches
    req_log.delete();
    do_miss(A + 16'd64, 1'b1, "R5", 1'b1);
    do_miss(C, 1'b0, "R5", 1'b1);
    idle(80);
    exp_log = {A + 16'd128, C, C + 16'd16, C + 16'd32, C + 16'd48, C + 16'd64};
    check_log("R5");

    // R7: flush empties and halts the stream
    req_log.delete();
    pulse_flush();
    idle(20);
    exp_log = {};
    check_log("R7");
    do_miss(C + 16'd16, 1'b0, "R7", 1'b1);
    idle(80);
    exp_log = {C + 16'd16, C + 16'd32, C + 16'd48, C + 16'd64, C + 16'd80};
    check_log("R7");

    // R8: prefetch in flight across a flush is dropped
    lat = 30;
    req_log.delete();
    do_miss(D, 1'b0, "R8", 1'b1);
    pulse_flush();
    idle(80);
    exp_log = {D, D + 16'd16};
    check_log("R8");
    do_miss(D + 16'd16, 1'b0, "R8", 1'b1);
    lat = 3;
    idle(200);

    // R9: wrap across the top of the address space
    req_log.delete();
    do_miss(16'hFFE0, 1'b0, "R9", 1'b1);
    idle(60);
    exp_log = {16'hFFE0, 16'hFFF0, 16'h0000, 16'h0010, 16'h0020};
    check_log("R9");
    do_miss(16'hFFF0, 1'b1, "R9", 1'b1);
    do_miss(16'h0000, 1'b1, "R9", 1'b1);
    idle(40);

    // R10: back-pressure on the response
    resp_ready = 1'b0;
    do_miss(16'h0010, 1'b1, "R10", 1'b0);
    @(negedge clk);
    held = resp_data;
    check(resp_valid == 1'b1, "R10", "stalled resp_valid", 64'(resp_valid), 64'd1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(resp_valid == 1'b1 && resp_data == held, "R10", "held response",
            64'(resp_data), 64'(held));
      check(miss_ready == 1'b0, "R10", "miss_ready while busy", 64'(miss_ready), 64'd0);
    end
    @(posedge clk); #1;
    resp_ready = 1'b1;
    while (exp_q.size() != 0) @(posedge clk);
    idle(40);

    check(viol == 0, "R6", "overlapping requests", 64'(viol), 64'd0);
    check(exp_q.size() == 0, "R1", "pending responses", 64'(exp_q.size()), 64'd0);
    summary();
    $finish;
  end
endmodule